// File: doc/BRIEF.md
# UART Interrupt Identification Controller

This block is the interrupt logic that sits behind the register interface of a 16550-style UART. The serial engines and FIFO storage report events to it: a line error, receive data reaching its trigger point, a receive character timeout, the transmit holding register going empty, and a modem line change. It keeps one sticky pending flag for each source, masks the flags with the interrupt enable bits, and reports the most urgent enabled source as a code in the identification byte. Each flag is cleared when software accesses the register that services it.

The host register decoder passes read strobes for the data, line status, modem status and identification registers, enable register writes, the FIFO-enable state and the modem-control gate bit. The block returns the identification byte, the enable register read value and the interrupt request line. Bits 7:6 of the identification byte show whether the FIFOs are on. Bits 5:4 always read as zero.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the identification byte reads 0x01, the enable readback reads 0x00 and the interrupt request is low.
- R2: An enable write stores 4 bits (bit0 receive data and timeout, bit1 transmit empty, bit2 line status, bit3 modem status). The readback byte returns them in bits 3:0, and bits 7:4 read as zero.
- R3: Identification bit 0 is 0 while an enabled source is pending and 1 otherwise. The low nibble codes are 0x6 line status, 0x4 receive data, 0xC character timeout, 0x2 transmit empty and 0x0 modem status.
- R4: Only the highest enabled pending source is reported. The order is line status, then receive data, then timeout, then transmit empty, then modem status.
- R5: A line status register read clears the line status source.
- R6: A data register read clears both the receive data source and the timeout source.
- R7: A modem status register read clears the modem status source.
- R8: An identification read clears the transmit-empty source only while that source is the one reported. The source also clears when the holding register stops being empty.
- R9: The transmit-empty source sets on a transition of the holding register to empty while its enable bit is 1. It also sets when its enable bit is written from 0 to 1 while the register is already empty.
- R10: Identification bits 7:6 read 11 when the FIFOs are enabled and 00 otherwise. Bits 5:4 always read 0.
- R11: The interrupt request is high exactly when identification bit 0 is 0 and the modem-control gate input is 1.
- R12: A source other than transmit-empty whose enable bit is 0 still latches its event. It is reported once its enable bit is set, and no clearing access has happened in between.
- R13: An event and the clearing access for the same source in one cycle leave the source pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ier_wr_i | input | 1 | Enable register write strobe |
| ier_wdata_i | input | 4 | Enable bits to write |
| fifo_en_i | input | 1 | FIFOs enabled |
| mcr_out2_i | input | 1 | Modem-control interrupt gate bit |
| lsr_evt_i | input | 1 | Line error event pulse |
| rxd_evt_i | input | 1 | Receive data ready event pulse |
| tmo_evt_i | input | 1 | Character timeout event pulse |
| msr_evt_i | input | 1 | Modem line change event pulse |
| thr_empty_i | input | 1 | Holding register empty level |
| rd_data_i | input | 1 | Data register read strobe |
| rd_lsr_i | input | 1 | Line status register read strobe |
| rd_msr_i | input | 1 | Modem status register read strobe |
| rd_iir_i | input | 1 | Identification register read strobe |
| iir_o | output | 8 | Identification byte |
| ier_o | output | 8 | Enable register readback |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default REG_W of 8, which gives the full 8-bit identification and enable bytes. The reserved-zero bits and the FIFO indication pair can therefore be observed at the ports. The bench drives all five event sources together and then retires them one at a time, so each step of the priority chain and each clearing access is visible. It also exercises the transmit-empty corner cases: an identification read while a different source is reported, re-arming through the enable bit, and clearing when the holding register refills.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int IER_W = 4;
  localparam int LAT_N = 4;

  // latched-source indices (transmit-empty is kept separately)
  localparam int L_LINE = 0;
  localparam int L_RXD  = 1;
  localparam int L_TMO  = 2;
  localparam int L_MDM  = 3;

  // enable bit positions
  localparam int E_RXD  = 0;
  localparam int E_THRE = 1;
  localparam int E_LINE = 2;
  localparam int E_MDM  = 3;

  localparam logic [3:0] CODE_NONE = 4'h1;
  localparam logic [3:0] CODE_LINE = 4'h6;
  localparam logic [3:0] CODE_RXD  = 4'h4;
  localparam logic [3:0] CODE_TMO  = 4'hC;
  localparam logic [3:0] CODE_THRE = 4'h2;
  localparam logic [3:0] CODE_MDM  = 4'h0;

  typedef struct packed {
    logic mdm;
    logic thre;
    logic tmo;
    logic rxd;
    logic line;
  } act_t;

  function automatic logic [3:0] pick_code(act_t a);
    logic [3:0] c;
    if (a.line)      c = CODE_LINE;
    else if (a.rxd)  c = CODE_RXD;
    else if (a.tmo)  c = CODE_TMO;
    else if (a.thre) c = CODE_THRE;
    else if (a.mdm)  c = CODE_MDM;
    else             c = CODE_NONE;
    return c;
  endfunction

  function automatic logic [7:0] ident_byte(logic [3:0] code, logic fifo_on);
    return {fifo_on, fifo_on, 2'b00, code};
  endfunction

endpackage

// File: rtl/uart_irq_flag.sv
module uart_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_o <= 1'b0;
    else if (set_i)  pend_o <= 1'b1;
    else if (clr_i)  pend_o <= 1'b0;
  end
endmodule

// File: rtl/uart_irq_thre.sv
module uart_irq_thre (
  input  logic clk,
  input  logic rst_n,
  input  logic empty_i,
  input  logic en_i,
  input  logic en_rise_i,
  input  logic ack_i,
  output logic set_o,
  output logic pend_o
);
  logic empty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) empty_q <= 1'b0;
    else        empty_q <= empty_i;
  end

  assign set_o = empty_i & ((~empty_q & en_i) | en_rise_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   pend_o <= 1'b0;
    else if (set_o)               pend_o <= 1'b1;
    else if (ack_i || !empty_i)   pend_o <= 1'b0;
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  act_t             act_i,
  input  logic             fifo_en_i,
  output logic [3:0]       code_o,
  output logic [REG_W-1:0] iir_o
);
  localparam int PAD_W = REG_W - 8;

  assign code_o = pick_code(act_i);

  generate
    if (PAD_W > 0) begin : g_pad
      assign iir_o = {{PAD_W{1'b0}}, ident_byte(code_o, fifo_en_i)};
    end else begin : g_nopad
      assign iir_o = ident_byte(code_o, fifo_en_i);
    end
  endgenerate
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ier_wr_i,
  input  logic [IER_W-1:0] ier_wdata_i,
  input  logic             fifo_en_i,
  input  logic             mcr_out2_i,
  input  logic             lsr_evt_i,
  input  logic             rxd_evt_i,
  input  logic             tmo_evt_i,
  input  logic             msr_evt_i,
  input  logic             thr_empty_i,
  input  logic             rd_data_i,
  input  logic             rd_lsr_i,
  input  logic             rd_msr_i,
  input  logic             rd_iir_i,
  output logic [REG_W-1:0] iir_o,
  output logic [REG_W-1:0] ier_o,
  output logic             irq_o
);
  localparam int ZPAD = REG_W - IER_W;

  logic [IER_W-1:0] ier_q;
  logic [LAT_N-1:0] lat_set, lat_clr, lat_pend;
  logic             thre_set_w, thre_pend_w, thre_ack_w, thre_en_rise_w;
  logic [3:0]       code_w;
  act_t             act_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ier_q <= '0;
    else if (ier_wr_i) ier_q <= ier_wdata_i;
  end
  assign ier_o = {{ZPAD{1'b0}}, ier_q};

  assign lat_set[L_LINE] = lsr_evt_i;
  assign lat_set[L_RXD]  = rxd_evt_i;
  assign lat_set[L_TMO]  = tmo_evt_i;
  assign lat_set[L_MDM]  = msr_evt_i;
  assign lat_clr[L_LINE] = rd_lsr_i;
  assign lat_clr[L_RXD]  = rd_data_i;
  assign lat_clr[L_TMO]  = rd_data_i;
  assign lat_clr[L_MDM]  = rd_msr_i;

  genvar g;
  generate
    for (g = 0; g < LAT_N; g++) begin : g_src
      uart_irq_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (lat_set[g]),
        .clr_i (lat_clr[g]),
        .pend_o(lat_pend[g])
      );
    end
  endgenerate

  assign thre_en_rise_w = ier_wr_i & ier_wdata_i[E_THRE] & ~ier_q[E_THRE];
  assign thre_ack_w     = rd_iir_i & (code_w == CODE_THRE);

  uart_irq_thre u_thre (
    .clk      (clk),
    .rst_n    (rst_n),
    .empty_i  (thr_empty_i),
    .en_i     (ier_q[E_THRE]),
    .en_rise_i(thre_en_rise_w),
    .ack_i    (thre_ack_w),
    .set_o    (thre_set_w),
    .pend_o   (thre_pend_w)
  );

  assign act_w.line = lat_pend[L_LINE] & ier_q[E_LINE];
  assign act_w.rxd  = lat_pend[L_RXD]  & ier_q[E_RXD];
  assign act_w.tmo  = lat_pend[L_TMO]  & ier_q[E_RXD];
  assign act_w.thre = thre_pend_w      & ier_q[E_THRE];
  assign act_w.mdm  = lat_pend[L_MDM]  & ier_q[E_MDM];

  uart_irq_prio #(.REG_W(REG_W)) u_prio (
    .act_i    (act_w),
    .fifo_en_i(fifo_en_i),
    .code_o   (code_w),
    .iir_o    (iir_o)
  );

  assign irq_o = ~iir_o[0] & mcr_out2_i;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mcr_out2_i,
  input logic             lsr_evt_i,
  input logic             rxd_evt_i,
  input logic             tmo_evt_i,
  input logic             msr_evt_i,
  input logic             rd_data_i,
  input logic             rd_lsr_i,
  input logic             rd_msr_i,
  input logic             rd_iir_i,
  input logic             thre_set,
  input logic [REG_W-1:0] iir_o,
  input logic [REG_W-1:0] ier_o,
  input logic             irq_o
);
  a_r5_lsr_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr_i && !lsr_evt_i) |=> (iir_o[3:0] != 4'h6));

  a_r6_data_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_i && !rxd_evt_i && !tmo_evt_i) |=> (iir_o[3:0] != 4'h4 && iir_o[3:0] != 4'hC));

  a_r7_msr_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_msr_i && !msr_evt_i) |=> (iir_o[3:0] != 4'h0));

  a_r8_thre_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_iir_i && iir_o[3:0] == 4'h2 && !thre_set) |=> (iir_o[3:0] != 4'h2));

  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_o[5:4] == 2'b00) && (ier_o[7:4] == 4'h0));

  a_r11_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !mcr_out2_i |-> !irq_o);

  a_r3_idle_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    iir_o[0] |-> !irq_o);
endmodule

bind uart_irq_ident uart_irq_ident_chk #(.REG_W(REG_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .mcr_out2_i(mcr_out2_i),
  .lsr_evt_i (lsr_evt_i),
  .rxd_evt_i (rxd_evt_i),
  .tmo_evt_i (tmo_evt_i),
  .msr_evt_i (msr_evt_i),
  .rd_data_i (rd_data_i),
  .rd_lsr_i  (rd_lsr_i),
  .rd_msr_i  (rd_msr_i),
  .rd_iir_i  (rd_iir_i),
  .thre_set  (thre_set_w),
  .iir_o     (iir_o),
  .ier_o     (ier_o),
  .irq_o     (irq_o)
);

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb_top;
  localparam int CLK_T = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ier_wr_i = 1'b0;
  logic [3:0] ier_wdata_i = '0;
  logic       fifo_en_i = 1'b0, mcr_out2_i = 1'b0;
  logic       lsr_evt_i = 1'b0, rxd_evt_i = 1'b0, tmo_evt_i = 1'b0, msr_evt_i = 1'b0;
  logic       thr_empty_i = 1'b0;
  logic       rd_data_i = 1'b0, rd_lsr_i = 1'b0, rd_msr_i = 1'b0, rd_iir_i = 1'b0;
  logic [7:0] iir_o, ier_o;
  logic       irq_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  uart_irq_ident dut_i (.*);

  always #(CLK_T/2) clk = ~clk;

  task automatic cyc;
    @(negedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic wr_ier(input logic [3:0] v);
    ier_wr_i = 1'b1; ier_wdata_i = v; cyc; ier_wr_i = 1'b0;
  endtask

  // which: 0 line, 1 rxd, 2 tmo, 3 msr
  task automatic evt(input int which);
    case (which)
      0: lsr_evt_i = 1'b1;
      1: rxd_evt_i = 1'b1;
      2: tmo_evt_i = 1'b1;
      default: msr_evt_i = 1'b1;
    endcase
    cyc;
    lsr_evt_i = 1'b0; rxd_evt_i = 1'b0; tmo_evt_i = 1'b0; msr_evt_i = 1'b0;
  endtask

  // which: 0 lsr, 1 data, 2 msr, 3 iir
  task automatic rd(input int which);
    case (which)
      0: rd_lsr_i = 1'b1;
      1: rd_data_i = 1'b1;
      2: rd_msr_i = 1'b1;
      default: rd_iir_i = 1'b1;
    endcase
    cyc;
    rd_lsr_i = 1'b0; rd_data_i = 1'b0; rd_msr_i = 1'b0; rd_iir_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 iir", iir_o, 8'h01);
    chk("R1 ier", ier_o, 8'h00);
    chk("R1 irq", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_ier;
    wr_ier(4'hD);
    chk("R2 ier readback", ier_o, 8'h0D);
    wr_ier(4'h0);
    chk("R2 ier cleared", ier_o, 8'h00);
  endtask

  task automatic t_priority;
    mcr_out2_i = 1'b1;
    wr_ier(4'hF);
    evt(3);
    chk("R3 modem code", iir_o, 8'h00);
    chk("R11 irq on", {7'd0, irq_o}, 8'h01);
    thr_empty_i = 1'b1; cyc;
    chk("R9 thre edge set", iir_o, 8'h02);
    evt(2);
    chk("R4 timeout over thre", iir_o, 8'h0C);
    evt(1);
    chk("R4 rxd over timeout", iir_o, 8'h04);
    evt(0);
    chk("R4 line highest", iir_o, 8'h06);
    rd(3);
    chk("R8 iir read while line shown", iir_o, 8'h06);
    rd(0);
    chk("R5 lsr read clears", iir_o, 8'h04);
    rd(1);
    chk("R6 data read clears rxd and timeout", iir_o, 8'h02);
    rd(3);
    chk("R8 iir read clears thre", iir_o, 8'h00);
    rd(3);
    chk("R8 iir read keeps modem", iir_o, 8'h00);
    rd(2);
    chk("R7 msr read clears", iir_o, 8'h01);
    chk("R11 irq off", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_timeout_alone;
    evt(2);
    chk("R3 timeout code", iir_o, 8'h0C);
    rd(1);
    chk("R6 data read clears timeout", iir_o, 8'h01);
  endtask

  task automatic t_thre_enable;
    // thr_empty is still 1 here, thre cleared earlier
    wr_ier(4'h0);
    chk("R9 no set while disabled", iir_o, 8'h01);
    wr_ier(4'h2);
    chk("R9 enable rise sets", iir_o, 8'h02);
    thr_empty_i = 1'b0; cyc;
    chk("R8 refill clears thre", iir_o, 8'h01);
  endtask

  task automatic t_masked;
    wr_ier(4'h0);
    evt(1);
    chk("R12 masked not shown", iir_o, 8'h01);
    wr_ier(4'h1);
    chk("R12 shown after enable", iir_o, 8'h04);
    rd_data_i = 1'b1; rxd_evt_i = 1'b1; cyc;
    rd_data_i = 1'b0; rxd_evt_i = 1'b0;
    chk("R13 set wins over clear", iir_o, 8'h04);
    rd(1);
    chk("R6 cleared", iir_o, 8'h01);
  endtask

  task automatic t_fifo_gate;
    fifo_en_i = 1'b1; cyc;
    chk("R10 fifo bits idle", iir_o, 8'hC1);
    evt(1);
    chk("R10 fifo bits pending", iir_o, 8'hC4);
    mcr_out2_i = 1'b0; cyc;
    chk("R11 gated off", {7'd0, irq_o}, 8'h00);
    mcr_out2_i = 1'b1; cyc;
    chk("R11 gated on", {7'd0, irq_o}, 8'h01);
    rd(1);
    fifo_en_i = 1'b0; cyc;
    chk("R10 fifo off", iir_o, 8'h01);
  endtask

  initial begin
    #(CLK_T * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc; cyc;
    t_reset;
    rst_n = 1'b1;
    cyc;
    t_reset;
    t_ier;
    t_priority;
    t_timeout_alone;
    t_thre_enable;
    t_masked;
    t_fifo_gate;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule